// File: doc/BRIEF.md
# Request Header Decoder and Queue

This block sits on the request side of an address-translation unit that is attached to a packet bus. Each bus request arrives as one 64-bit header word and one 32-bit data word, offered together on a valid/ready input stream. The block decides in the same cycle whether the request is meant for this unit. It recognises four request kinds: translate, IO read, IO write and broadcast IO write. It checks the device type and device number carried in the address, and it applies a page-subset filter to translate requests and to table-entry IO operations. An accepted request becomes a 78-bit record and is pushed into a 16-deep first-in first-out queue. A request that fails acceptance is dropped without trace.

A write from user mode is not refused at the bus. It is queued with an access-error mark, so the execution stage can skip the write and still send an error reply. The queue is read through a valid/ready output stream, and the block also provides a full flag. Back-pressure rules: `in_ready` is low only when the offered request would be accepted and the queue is full. Such a request must then be held stable until `in_ready` rises. Requests that would be dropped always see `in_ready` high. `full` reflects the occupancy at the start of the cycle, so a pop in a cycle where the queue is full does not admit a push in that same cycle. On the output side, `out_rec` stays stable while `out_valid` is high and `out_ready` is low.

Top module: `rq_header_queue`

## Requirements
- R1: After reset the queue is empty: `out_valid`=0, `full`=0, and `in_ready`=1.
- R2: A translate request (header bits [63:59]=5'b11100) is accepted exactly when its page, taken from address bits [31:10], satisfies (page AND `sub_mask`) == (`sub_pat` AND `sub_mask`).
- R3: An IO read (5'b10000) or IO write (5'b10010) is accepted only when address bits [31:28]==5 and address bits [27:24] equal `dev_id`[3:0].
- R4: A broadcast IO write (5'b10100) is accepted only when address bits [31:28]==5. The device number in bits [27:24] is not checked.
- R5: For IO requests, address bit 23 set marks a register operation, which skips the subset filter. With bit 23 clear, the request is an entry operation and also needs address bits [21:0] to pass the R2 subset test.
- R6: An accepted IO write or broadcast write with header bit 58 = 1 (user mode) is queued with its error bit set. Translate and read records always carry error bit 0, as do writes with bit 58 = 0.
- R7: Queue record layout is {err[77], cmd[76:74], requester id[73:64] = header[56:47], address[63:32] = header[31:0], data[31:0] = `in_data`}. The command codes are 0 for translate, 1 for read, 2 for write and 3 for broadcast write.
- R8: A request that fails acceptance, including any other header bits [63:59] value, is consumed with `in_ready`=1 and never reaches the output.
- R9: Records leave in arrival order. The queue holds 16 records, and `full` is 1 exactly when 16 are stored.
- R10: An acceptable request offered while the queue is full sees `in_ready`=0 and is not queued. Once a pop has made room, it is queued on the next cycle in which it is still offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request consumed this cycle |
| in_hdr | input | 64 | Request header word |
| in_data | input | 32 | Request data word |
| dev_id | input | 10 | This unit's device ID |
| sub_mask | input | 22 | Page-subset mask |
| sub_pat | input | 22 | Page-subset pattern |
| out_valid | output | 1 | Queue head is valid |
| out_ready | input | 1 | Consumer takes the head |
| out_rec | output | 78 | Queue head record |
| full | output | 1 | Queue holds 16 records |

## Verification
Translate requests are sent with pages just inside and just outside the subset. This separates the use of the high page field from the use of the low one. IO reads and writes are offered with the right and wrong device number and type, and with the register bit set and clear against a failing page. Broadcast writes use a foreign device number. Together these show which checks apply to which command. Further cases cover user-mode writes versus user-mode reads, an unknown command, and a fill to 16 followed by a held 17th request. Those cases separate error marking, silent drop and the timing of the full-queue stall and release.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int HDR_W  = 64;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 10;
  localparam int PAGE_W = 22;

  localparam logic [4:0] OP_XLATE = 5'b11100;
  localparam logic [4:0] OP_RD    = 5'b10000;
  localparam logic [4:0] OP_WR    = 5'b10010;
  localparam logic [4:0] OP_BWR   = 5'b10100;

  typedef enum logic [2:0] {
    CMD_XLATE = 3'd0,
    CMD_RD    = 3'd1,
    CMD_WR    = 3'd2,
    CMD_BWR   = 3'd3
  } rq_cmd_e;

  typedef struct packed {
    logic              acc_err;
    rq_cmd_e           cmd;
    logic [ID_W-1:0]   rqid;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } rq_rec_t;

  localparam int REC_W = $bits(rq_rec_t);
endpackage

// File: rtl/rq_subset_match.sv
module rq_subset_match #(
  parameter int W = 22
) (
  input  logic [W-1:0] page,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] pat,
  output logic         hit
);
  assign hit = ((page ^ pat) & mask) == '0;
endmodule

// File: rtl/rq_decode.sv
module rq_decode
  import rq_pkg::*;
#(
  parameter logic [3:0] UNIT_TYPE = 4'd5
) (
  input  logic [HDR_W-1:0]  hdr,
  input  logic [DATA_W-1:0] data,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [PAGE_W-1:0] sub_mask,
  input  logic [PAGE_W-1:0] sub_pat,
  output logic              accept,
  output rq_rec_t           rec
);
  logic [4:0]        op;
  logic              user_mode;
  logic [ADDR_W-1:0] addr;
  logic is_x, is_rd, is_wr, is_bw;
  logic type_ok, num_ok, reg_op, hit_x, hit_io, io_pass;

  assign op        = hdr[63:59];
  assign user_mode = hdr[58];
  assign addr      = hdr[ADDR_W-1:0];

  assign is_x  = (op == OP_XLATE);
  assign is_rd = (op == OP_RD);
  assign is_wr = (op == OP_WR);
  assign is_bw = (op == OP_BWR);

  assign type_ok = (addr[31:28] == UNIT_TYPE);
  assign num_ok  = (addr[27:24] == dev_id[3:0]);
  assign reg_op  = addr[23];

  rq_subset_match #(.W(PAGE_W)) u_xlate_filt (
    .page(addr[ADDR_W-1:ADDR_W-PAGE_W]), .mask(sub_mask), .pat(sub_pat), .hit(hit_x)
  );
  rq_subset_match #(.W(PAGE_W)) u_io_filt (
    .page(addr[PAGE_W-1:0]), .mask(sub_mask), .pat(sub_pat), .hit(hit_io)
  );

  assign io_pass = reg_op | hit_io;

  assign accept = (is_x & hit_x)
                | ((is_rd | is_wr) & type_ok & num_ok & io_pass)
                | (is_bw & type_ok & io_pass);

  always_comb begin
    rec.acc_err = (is_wr | is_bw) & user_mode;
    rec.rqid    = hdr[56:47];
    rec.addr    = addr;
    rec.data    = data;
    unique case (1'b1)
      is_rd:   rec.cmd = CMD_RD;
      is_wr:   rec.cmd = CMD_WR;
      is_bw:   rec.cmd = CMD_BWR;
      default: rec.cmd = CMD_XLATE;
    endcase
  end
endmodule

// File: rtl/rq_fifo.sv
module rq_fifo #(
  parameter int WIDTH = 78,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_p, rd_p;
  logic             do_push, do_pop;

  assign empty   = (wr_p == rd_p);
  assign full    = (wr_p[AW] != rd_p[AW]) && (wr_p[AW-1:0] == rd_p[AW-1:0]);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rd_p[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
    end else begin
      if (do_push) wr_p <= wr_p + 1'b1;
      if (do_pop)  rd_p <= rd_p + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/rq_header_queue.sv
module rq_header_queue
  import rq_pkg::*;
#(
  parameter int         DEPTH     = 16,
  parameter logic [3:0] UNIT_TYPE = 4'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [PAGE_W-1:0] sub_mask,
  input  logic [PAGE_W-1:0] sub_pat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [REC_W-1:0]  out_rec,
  output logic              full
);
  logic    accept, empty, push;
  rq_rec_t rec;

  rq_decode #(.UNIT_TYPE(UNIT_TYPE)) u_dec (
    .hdr(in_hdr), .data(in_data), .dev_id(dev_id),
    .sub_mask(sub_mask), .sub_pat(sub_pat),
    .accept(accept), .rec(rec)
  );

  assign in_ready  = ~(accept & full);
  assign push      = in_valid & accept;
  assign out_valid = ~empty;

  rq_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(push), .wdata(rec),
    .pop(out_ready), .rdata(out_rec),
    .empty(empty), .full(full)
  );
endmodule

// File: rtl/rq_header_queue_chk.sv
module rq_header_queue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_hdr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [77:0] out_rec,
  input logic        full
);
  logic known_op;
  assign known_op = (in_hdr[63:59] == 5'b11100) || (in_hdr[63:59] == 5'b10000) ||
                    (in_hdr[63:59] == 5'b10010) || (in_hdr[63:59] == 5'b10100);

  p_stall_only_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> full);
  p_full_has_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> out_valid);
  p_head_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));
  p_unknown_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !known_op) |-> in_ready);
  p_cmd_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rec[76] == 1'b0));
  p_err_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rec[77]) |-> (out_rec[76:74] == 3'd2 || out_rec[76:74] == 3'd3));
endmodule

bind rq_header_queue rq_header_queue_chk chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_hdr(in_hdr), .out_valid(out_valid), .out_ready(out_ready),
  .out_rec(out_rec), .full(full)
);

// File: tb/rq_header_queue_test.sv
`timescale 1ns/1ps
module rq_header_queue_test;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, out_ready = 0;
  logic [63:0] in_hdr = '0;
  logic [31:0] in_data = '0;
  logic [9:0]  dev_id = 10'h2A7;
  logic [21:0] sub_mask = 22'h000003, sub_pat = 22'h000001;
  logic        in_ready, out_valid, full;
  logic [77:0] out_rec;

  int errors = 0, checks = 0;
  logic [77:0] mq[$];

  always #4 clk = ~clk;

  rq_header_queue uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_data(in_data), .dev_id(dev_id),
    .sub_mask(sub_mask), .sub_pat(sub_pat), .out_valid(out_valid),
    .out_ready(out_ready), .out_rec(out_rec), .full(full)
  );

  function automatic logic [63:0] mk(input logic [4:0] op, input logic mode,
                                     input logic [9:0] id, input logic [31:0] a);
    return {op, mode, 1'b0, id, 15'd0, a};
  endfunction

  function automatic logic [31:0] ioa(input int typ, input int num, input logic f0,
                                      input logic [21:0] vp);
    return {typ[3:0], num[3:0], f0, 1'b0, vp};
  endfunction

  function automatic bit in_sub(input logic [21:0] vp);
    return (vp & sub_mask) == (sub_pat & sub_mask);
  endfunction

  // behavioural reference: returns acceptance, fills the expected record
  function automatic bit ref_acc(input logic [63:0] h, input logic [31:0] d,
                                 output logic [77:0] r);
    int op = h[63:59];
    int typ = h[31:28];
    int num = h[27:24];
    bit entry_ok = h[23] || in_sub(h[21:0]);
    bit ok = 0;
    int c = 0;
    bit e = 0;
    if (op == 28) begin ok = in_sub(h[31:10]); c = 0; end
    else if (op == 16) begin ok = typ == 5 && num == dev_id[3:0] && entry_ok; c = 1; end
    else if (op == 18) begin ok = typ == 5 && num == dev_id[3:0] && entry_ok; c = 2; e = h[58]; end
    else if (op == 20) begin ok = typ == 5 && entry_ok; c = 3; e = h[58]; end
    r = {e, c[2:0], h[56:47], h[31:0], d};
    return ok;
  endfunction

  task automatic chk(input string tag, input string what, input logic [77:0] got,
                     input logic [77:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [63:0] h, input logic [31:0] d,
                      input logic ordy, input string tag);
    logic [77:0] r;
    bit acc, push, pop;
    int n;
    @(negedge clk);
    in_valid = v; in_hdr = h; in_data = d; out_ready = ordy;
    #1;
    n = mq.size();
    acc = ref_acc(h, d, r);
    chk(tag, "in_ready", {77'd0, in_ready}, {77'd0, !(acc && n == 16)});
    chk("R9", "full", {77'd0, full}, {77'd0, n == 16});
    chk("R9", "out_valid", {77'd0, out_valid}, {77'd0, n > 0});
    if (n > 0) chk("R7", "out_rec", out_rec, mq[0]);
    push = v && acc && n < 16;
    pop = ordy && n > 0;
    @(posedge clk);
    if (pop) void'(mq.pop_front());
    if (push) mq.push_back(r);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step(0, '0, '0, 1, "R1");
    // R2 translate inside / outside subset
    step(1, mk(5'b11100, 0, 10'h011, {22'h12345, 10'h3FF}), 32'hA1, 1, "R2");
    step(1, mk(5'b11100, 0, 10'h012, {22'h12346, 10'h000}), 32'hA2, 1, "R2");
    step(1, mk(5'b11100, 0, 10'h013, {22'h00002, 10'h001}), 32'hA3, 1, "R2");
    // R3 device number and type on reads/writes
    step(1, mk(5'b10000, 0, 10'h021, ioa(5, 7, 0, 22'h00001)), 32'hB1, 1, "R3");
    step(1, mk(5'b10000, 0, 10'h022, ioa(5, 6, 0, 22'h00001)), 32'hB2, 1, "R3");
    step(1, mk(5'b10010, 0, 10'h023, ioa(4, 7, 1, 22'h00001)), 32'hB3, 1, "R3");
    step(1, mk(5'b10010, 0, 10'h024, ioa(5, 7, 0, 22'h3FFF5)), 32'hB4, 1, "R3");
    // R5 register bit bypasses the subset filter
    step(1, mk(5'b10010, 0, 10'h031, ioa(5, 7, 1, 22'h00002)), 32'hC1, 1, "R5");
    step(1, mk(5'b10010, 0, 10'h032, ioa(5, 7, 0, 22'h00002)), 32'hC2, 1, "R5");
    step(1, mk(5'b10000, 0, 10'h033, ioa(5, 7, 1, 22'h00000)), 32'hC3, 1, "R5");
    // R4 broadcast ignores device number
    step(1, mk(5'b10100, 0, 10'h041, ioa(5, 3, 1, 22'h00000)), 32'hD1, 1, "R4");
    step(1, mk(5'b10100, 0, 10'h042, ioa(6, 7, 1, 22'h00000)), 32'hD2, 1, "R4");
    step(1, mk(5'b10100, 0, 10'h043, ioa(5, 9, 0, 22'h00002)), 32'hD3, 1, "R4");
    // R6 user mode
    step(1, mk(5'b10010, 1, 10'h051, ioa(5, 7, 1, 22'h00000)), 32'hE1, 1, "R6");
    step(1, mk(5'b10000, 1, 10'h052, ioa(5, 7, 1, 22'h00000)), 32'hE2, 1, "R6");
    step(1, mk(5'b10100, 1, 10'h053, ioa(5, 1, 0, 22'h00001)), 32'hE3, 1, "R6");
    step(1, mk(5'b11100, 1, 10'h054, {22'h00001, 10'h0}), 32'hE4, 1, "R6");
    // R8 unknown commands dropped
    step(1, mk(5'b10001, 0, 10'h061, ioa(5, 7, 1, 22'h00001)), 32'hF1, 1, "R8");
    step(1, mk(5'b11101, 0, 10'h062, {22'h00001, 10'h0}), 32'hF2, 1, "R8");
    repeat (3) step(0, '0, '0, 1, "R9");
    // R9 fill in order, no reads
    for (int i = 0; i < 16; i++)
      step(1, mk(5'b10000, 0, 10'(i), ioa(5, 7, 1, 22'(i))), 32'(i * 3), 0, "R9");
    // R10 held 17th request while full
    for (int i = 0; i < 3; i++)
      step(1, mk(5'b10010, 0, 10'h3AA, ioa(5, 7, 1, 22'h0)), 32'hCAFE, 0, "R10");
    step(1, mk(5'b10111, 0, 10'h3AB, 32'h0), 32'h0, 0, "R8");
    step(1, mk(5'b10010, 0, 10'h3AA, ioa(5, 7, 1, 22'h0)), 32'hCAFE, 1, "R10");
    step(1, mk(5'b10010, 0, 10'h3AA, ioa(5, 7, 1, 22'h0)), 32'hCAFE, 0, "R10");
    step(0, '0, '0, 0, "R10");
    for (int i = 0; i < 20; i++) step(0, '0, '0, 1, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule